// File: doc/BRIEF.md
# Two-Wire Configuration Slave with Broadcast Reset

This block is the serial slave port of a small measurement device. It watches the two-wire bus through synchronisers running on the system clock and detects start, repeated-start and stop conditions from those synchronised lines. It shifts in the address byte and decides whether to acknowledge it. It only ever pulls the data line low, through an output-enable, and it never drives the clock line.

When its own address arrives with the read bit set, it returns the 16-bit conversion result and then the configuration byte, most significant bit first. With the write bit clear, it accepts one data byte and presents it to the surrounding logic with a one-cycle write strobe. It also answers the broadcast address. One broadcast command byte raises a one-cycle reset request, and one other command byte is merely acknowledged. The high-speed master code is never acknowledged, but it sets a mode flag that stays up until the next stop.

Top module: `i2c_cfg_slave`

## Requirements
- R1: SCL and SDA each pass through a two-flop synchroniser. A start (SDA falling while SCL is high) begins a new address byte, including when the bus is already active (repeated start). A stop (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R2: An address byte whose upper seven bits equal 7'h48 (0x90 write, 0x91 read) is acknowledged by SDA held low through the ninth clock. Every other address byte, except 0x00, is left unacknowledged. The slave changes its SDA drive only while SCL is low.
- R3: After 0x90, the first data byte is acknowledged and produces exactly one cycle of `cfg_wr_o` with that byte on `cfg_data_o`. Further data bytes in the same transfer are not acknowledged and produce no strobe.
- R4: After 0x91, the bytes returned MSB first are result[15:8], result[7:0], the configuration byte, and then 0xFF (SDA released) for every byte after those.
- R5: The result is captured when the read address is accepted. A change of `result_i` during the transfer does not alter the bytes being returned.
- R6: A not-acknowledge from the master after a read byte ends the read. SDA stays released, and further clocks return 0xFF until the next start or stop.
- R7: Address byte 0x00 (broadcast, write) is always acknowledged. Command byte 0x06 is acknowledged and raises `reset_req_o` for exactly one cycle, in the same cycle that the acknowledge drive (`sda_oe_o`) turns on. Command byte 0x04 is acknowledged with no reset. Every other command byte, and address byte 0x01, is not acknowledged.
- R8: An address byte with bits [7:3] equal to 5'b00001 is not acknowledged and sets `hs_mode_o`. The flag survives a repeated start and clears at the next stop.
- R9: After an address that is not acknowledged, the slave ignores all bytes and leaves SDA released until the next start or stop.
- R10: After reset, `sda_oe_o`, `cfg_wr_o`, `reset_req_o` and `hs_mode_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| result_i | input | 16 | Conversion result, two's complement |
| cfg_i | input | 8 | Current configuration byte, returned third on reads |
| cfg_wr_o | output | 1 | One-cycle strobe for a received configuration byte |
| cfg_data_o | output | 8 | Configuration byte that goes with `cfg_wr_o` |
| reset_req_o | output | 1 | One-cycle request for a full device reset |
| hs_mode_o | output | 1 | High-speed master code seen since the last stop |

## Verification
The broadcast reset request and the acknowledge drive for the same command byte are meant to fall in one clock cycle. A sweep sends every possible command byte after the broadcast address to provoke this. A monitor running on the falling clock edge counts each cycle in which `reset_req_o` is high while `sda_oe_o` is low. That count must stay at zero, and exactly one reset pulse must appear across the whole sweep, on command 0x06.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACK, ST_SEND, ST_MACK, ST_IGNORE
  } st_e;

  typedef enum logic [1:0] {RX_ADDR, RX_WDATA, RX_BCAST} rx_e;

  localparam logic [7:0] BCAST_ADDR  = 8'h00;
  localparam logic [7:0] BCAST_RESET = 8'h06;
  localparam logic [7:0] BCAST_KEEP  = 8'h04;
  localparam logic [4:0] HS_PREFIX   = 5'b00001;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw;
  logic [1:0] lvl;
  logic [1:0] lvl_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 2'b11;
    else         lvl_q <= lvl;
  end

  assign scl_o      = lvl[0];
  assign sda_o      = lvl[1];
  assign scl_rise_o = lvl[0] & ~lvl_q[0];
  assign scl_fall_o = ~lvl[0] & lvl_q[0];
  // conditions need SCL high on both samples
  assign start_o    = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
  assign stop_o     = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_o <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
    end else if (shift_i) begin
      cnt_q  <= cnt_q + 1'b1;
      data_o <= {data_o[W-2:0], bit_i};
    end
  end

  assign full_o = (cnt_q == CNT_W'(W));
endmodule

// File: rtl/i2c_rd_select.sv
module i2c_rd_select #(
  parameter int RES_W = 16,
  parameter int IDX_W = 2
) (
  input  logic [RES_W-1:0] res_i,
  input  logic [7:0]       cfg_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  localparam int RES_BYTES = RES_W / 8;

  always_comb begin
    byte_o = 8'hFF;
    for (int k = 0; k < RES_BYTES; k++) begin
      if (int'(idx_i) == k) byte_o = res_i[RES_W-1-8*k -: 8];
    end
    if (int'(idx_i) == RES_BYTES) byte_o = cfg_i;
  end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h48,
  parameter int         SYNC_STAGES = 2,
  parameter int         RES_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [RES_W-1:0] result_i,
  input  logic [7:0]       cfg_i,
  output logic             cfg_wr_o,
  output logic [7:0]       cfg_data_o,
  output logic             reset_req_o,
  output logic             hs_mode_o
);
  localparam int RES_BYTES = RES_W / 8;
  localparam int IDX_MAX   = RES_BYTES + 1;
  localparam int IDX_W     = $clog2(IDX_MAX + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rx_byte, rd_byte;
  logic rx_full, cnt_clr, cnt_shift;

  st_e  st_q, ack_nxt_q;
  rx_e  rx_q;
  logic wr_done_q, mack_q, sda_oe_q, cfg_wr_q, rst_req_q, hs_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0] tx_q, cfg_data_q;
  logic [RES_W-1:0] res_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign cnt_shift = scl_rise & (st_q == ST_RECV || st_q == ST_SEND);
  assign cnt_clr   = start_det | (scl_fall & rx_full & (st_q == ST_RECV || st_q == ST_SEND));

  i2c_byte_shift #(.W(8)) u_shift (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .shift_i(cnt_shift), .bit_i(sda_s),
    .data_o(rx_byte), .full_o(rx_full)
  );

  i2c_rd_select #(.RES_W(RES_W), .IDX_W(IDX_W)) u_sel (
    .res_i(res_q), .cfg_i, .idx_i(idx_q), .byte_o(rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ack_nxt_q  <= ST_IDLE;
      rx_q       <= RX_ADDR;
      wr_done_q  <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      cfg_wr_q   <= 1'b0;
      cfg_data_q <= '0;
      rst_req_q  <= 1'b0;
      hs_q       <= 1'b0;
      idx_q      <= '0;
      tx_q       <= '1;
      res_q      <= '0;
    end else begin
      cfg_wr_q  <= 1'b0;
      rst_req_q <= 1'b0;
      if (stop_det) begin
        st_q     <= ST_IDLE;
        sda_oe_q <= 1'b0;
        hs_q     <= 1'b0;
      end else if (start_det) begin
        st_q     <= ST_RECV;
        rx_q     <= RX_ADDR;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RECV: if (scl_fall && rx_full) begin
            unique case (rx_q)
              RX_ADDR: begin
                if (rx_byte[7:1] == SLAVE_ADDR) begin
                  sda_oe_q  <= 1'b1;
                  st_q      <= ST_ACK;
                  idx_q     <= '0;
                  res_q     <= result_i;
                  wr_done_q <= 1'b0;
                  rx_q      <= RX_WDATA;
                  ack_nxt_q <= rx_byte[0] ? ST_SEND : ST_RECV;
                end else if (rx_byte == BCAST_ADDR) begin
                  sda_oe_q  <= 1'b1;
                  st_q      <= ST_ACK;
                  rx_q      <= RX_BCAST;
                  ack_nxt_q <= ST_RECV;
                end else begin
                  st_q <= ST_IGNORE;
                  if (rx_byte[7:3] == HS_PREFIX) hs_q <= 1'b1;
                end
              end
              RX_WDATA: begin
                if (!wr_done_q) begin
                  sda_oe_q   <= 1'b1;
                  st_q       <= ST_ACK;
                  ack_nxt_q  <= ST_RECV;
                  wr_done_q  <= 1'b1;
                  cfg_wr_q   <= 1'b1;
                  cfg_data_q <= rx_byte;
                end else begin
                  st_q <= ST_IGNORE;
                end
              end
              default: begin
                if (rx_byte == BCAST_RESET || rx_byte == BCAST_KEEP) begin
                  sda_oe_q  <= 1'b1;
                  st_q      <= ST_ACK;
                  ack_nxt_q <= ST_IGNORE;
                  rst_req_q <= (rx_byte == BCAST_RESET);
                end else begin
                  st_q <= ST_IGNORE;
                end
              end
            endcase
          end
          ST_ACK: if (scl_fall) begin
            st_q <= ack_nxt_q;
            if (ack_nxt_q == ST_SEND) begin
              tx_q     <= rd_byte;
              sda_oe_q <= ~rd_byte[7];
            end else begin
              sda_oe_q <= 1'b0;
            end
          end
          ST_SEND: if (scl_fall) begin
            if (rx_full) begin
              sda_oe_q <= 1'b0;
              st_q     <= ST_MACK;
            end else begin
              tx_q     <= {tx_q[6:0], 1'b1};
              sda_oe_q <= ~tx_q[6];
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
              if (!sda_s && int'(idx_q) < IDX_MAX) idx_q <= idx_q + 1'b1;
            end
            if (scl_fall) begin
              if (mack_q) begin
                st_q     <= ST_SEND;
                tx_q     <= rd_byte;
                sda_oe_q <= ~rd_byte[7];
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign cfg_wr_o    = cfg_wr_q;
  assign cfg_data_o  = cfg_data_q;
  assign reset_req_o = rst_req_q;
  assign hs_mode_o   = hs_q;

  assert_drive_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !$past(scl_s));
  assert_cfg_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> !cfg_wr_o);
  assert_reset_with_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> sda_oe_o);
  assert_reset_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o);
  assert_hs_no_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> !sda_oe_q);
  assert_hs_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !hs_q);
  assert_ignore_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IGNORE) |-> !sda_oe_q);
  assert_stop_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (st_q == ST_IDLE && !sda_oe_q));
endmodule

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [15:0] result = 16'hFFFF;
  logic [7:0] cfg = 8'h8C;
  logic sda_oe, cfg_wr, rst_req, hs_mode;
  logic [7:0] cfg_data;
  wire sda_bus = m_sda & ~sda_oe;

  int checks = 0, errors = 0;
  int cfg_cnt = 0, rst_cnt = 0, coin_err = 0;
  logic [7:0] cfg_last = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_cfg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .result_i(result), .cfg_i(cfg),
    .cfg_wr_o(cfg_wr), .cfg_data_o(cfg_data), .reset_req_o(rst_req), .hs_mode_o(hs_mode)
  );

  always @(negedge clk) begin
    if (cfg_wr) begin cfg_cnt++; cfg_last = cfg_data; end
    if (rst_req) begin
      rst_cnt++;
      if (!sda_oe) coin_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = d[i]; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0;
    end
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    ack = ~sda_bus;
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1'b1; wq(Q); d[i] = sda_bus; m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1;
    wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(1); m_sda = 1'b1;
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    int c0;
    wq(4);
    // R10 reset state
    chk(!sda_oe && !cfg_wr && !rst_req && !hs_mode, "R10 reset outputs",
        {sda_oe, cfg_wr, rst_req, hs_mode}, 0);
    rst_n = 1'b1;
    wq(4);

    // R2/R8: every address byte
    result = 16'hFFFF;
    for (int b = 0; b < 256; b++) begin
      bit exp_ack, exp_hs;
      exp_ack = (b[7:1] == 7'h48) || (b == 0);
      exp_hs  = (b[7:3] == 5'b00001);
      bus_start();
      wbyte(8'(b), ack);
      chk(ack == exp_ack, $sformatf("R2 addr ack byte %02h", b), ack, exp_ack);
      chk(hs_mode == exp_hs, $sformatf("R8 hs flag byte %02h", b), hs_mode, exp_hs);
      bus_stop();
      chk(!hs_mode && !sda_oe, "R1 stop idles and R8 clears", {hs_mode, sda_oe}, 0);
    end

    // R3 writes
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'((i * 37) ^ 8'hA5);
      c0 = cfg_cnt;
      bus_start();
      wbyte(8'h90, ack);
      chk(ack, "R2 write addr ack", ack, 1);
      wbyte(v, ack);
      chk(ack, "R3 data ack", ack, 1);
      chk(cfg_cnt == c0 + 1 && cfg_last == v, "R3 strobe/data", cfg_last, v);
      wbyte(~v, ack);
      chk(!ack && cfg_cnt == c0 + 1, "R3 extra byte refused", cfg_cnt - c0, 1);
      bus_stop();
    end

    // R4/R5 read order and snapshot
    result = 16'hA53C; cfg = 8'h8C;
    bus_start();
    wbyte(8'h91, ack);
    chk(ack, "R2 read addr ack", ack, 1);
    result = 16'h1234;
    rbyte(1, d); chk(d == 8'hA5, "R4/R5 byte0", d, 8'hA5);
    rbyte(1, d); chk(d == 8'h3C, "R4/R5 byte1", d, 8'h3C);
    rbyte(1, d); chk(d == 8'h8C, "R4 cfg byte", d, 8'h8C);
    rbyte(1, d); chk(d == 8'hFF, "R4 byte3 idle", d, 8'hFF);
    rbyte(0, d); chk(d == 8'hFF, "R4 byte4 idle", d, 8'hFF);
    bus_stop();

    // R6 master NACK ends read
    bus_start();
    wbyte(8'h91, ack);
    rbyte(0, d); chk(d == 8'h12, "R6 first byte", d, 8'h12);
    rbyte(1, d); chk(d == 8'hFF, "R6 released after nack", d, 8'hFF);
    bus_stop();

    // R1 repeated start
    bus_start();
    wbyte(8'h90, ack);
    bus_start();
    wbyte(8'h91, ack);
    chk(ack, "R1 repeated start addr", ack, 1);
    rbyte(0, d); chk(d == 8'h12, "R1 read after restart", d, 8'h12);
    bus_stop();

    // R8 high-speed code persists over repeated start
    c0 = cfg_cnt;
    bus_start();
    wbyte(8'h0B, ack);
    chk(!ack && hs_mode, "R8 hs code nack+flag", {ack, hs_mode}, 1);
    bus_start();
    wbyte(8'h90, ack);
    chk(ack && hs_mode, "R8 hs kept on restart", {ack, hs_mode}, 3);
    wbyte(8'h33, ack);
    chk(ack && cfg_last == 8'h33 && cfg_cnt == c0 + 1, "R3 write in hs", cfg_last, 8'h33);
    bus_stop();
    chk(!hs_mode, "R8 hs clear at stop", hs_mode, 0);

    // R9 ignore after foreign address
    c0 = cfg_cnt;
    bus_start();
    wbyte(8'h92, ack); chk(!ack, "R9 foreign nack", ack, 0);
    wbyte(8'h90, ack); chk(!ack, "R9 ignored own addr", ack, 0);
    wbyte(8'h00, ack); chk(!ack && cfg_cnt == c0, "R9 ignored bcast", ack, 0);
    bus_stop();

    // R7 broadcast command sweep
    for (int v = 0; v < 256; v++) begin
      bit exp_ack;
      int r0;
      exp_ack = (v == 6) || (v == 4);
      r0 = rst_cnt;
      bus_start();
      wbyte(8'h00, ack);
      chk(ack, "R7 bcast addr ack", ack, 1);
      wbyte(8'(v), ack);
      chk(ack == exp_ack, $sformatf("R7 cmd %02h ack", v), ack, exp_ack);
      chk(rst_cnt == r0 + ((v == 6) ? 1 : 0), $sformatf("R7 cmd %02h reset", v),
          rst_cnt - r0, (v == 6) ? 1 : 0);
      bus_stop();
    end
    chk(rst_cnt == 1, "R7 total resets", rst_cnt, 1);
    chk(coin_err == 0, "R7 reset coincides with ack", coin_err, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule